// File: doc/BRIEF.md
# Configurable Digital I/O Channel

This block controls one digital I/O line behind a small byte-wide register port. The host uses it to choose whether the channel senses a pin or drives one. In input mode the channel reports a synchronised copy of `pin_in`. When input simulation is switched on, it reports a host-written value instead. In output mode the host sets a flag that drives `pin_out`. The two reported flags then mirror that output flag.

Three flags are visible in one status byte: a control flag, an input flag and an output flag. The host can select a rising or a falling edge on any of them as a notification event. A selected edge gives a one-cycle `notify` pulse and sets a sticky pending bit. The host clears that bit by writing 1 to it.

Eight error inputs feed two bytes. The live byte copies the inputs. The history byte holds each error until the host reads it. Input 7 is a module-wide fault, and while it is set the other error bits are hidden.

The channel is controlled by a three-state machine:
- `ST_IN_PIN`: input mode, reading the pin.
- `ST_IN_SIM`: input mode with simulation on.
- `ST_OUT`: output mode.

The transitions are:
- `T_TO_OUT`: a mode write of 2 from either input state.
- `T_TO_IN`: a mode write of any other value while in `ST_OUT`. It goes to `ST_IN_SIM` or `ST_IN_PIN` according to the stored simulation bit.
- `T_SIM_ON` / `T_SIM_OFF`: an enable write in an input state whose bit 0 is 1 / 0.

Top module: `dio_channel`

## Requirements
- R1: Register addresses are 0 flags, 1 enable, 2 mode, 3 notify enable, 4 pending, 5 live errors, 6 error history. Address 7 reads 0. In the flags byte, bit 7 is the output flag, bit 6 the input flag and bit 3 the control flag, and the other bits read 0. Read data appears on `bus_rdata` the cycle after `bus_rd` is sampled, and is 0 in cycles with no read.
- R2: Writing 2 to the mode register selects output mode, and any other value selects input mode. The mode register reads back 2 or 0, and its reset value is 0.
- R3: In input mode with simulation off, the input flag equals `pin_in` after a two-stage synchroniser, and the control flag equals the input flag.
- R4: In output mode, the input and control flags both follow the output flag, and `pin_in` has no effect on them.
- R5: `pin_out` equals the output flag. A write to flags bit 7 updates it only in output mode. The output flag is cleared when the channel leaves output mode, so `pin_out` is 0 throughout input mode.
- R6: Enable bit 0 turns input simulation on, and it is the only readable enable bit. In `ST_IN_SIM`, the input flag is the value last written to flags bit 6 while in that state (0 after reset), and `pin_in` is ignored. Writes to bit 6 in any other state are ignored.
- R7: The notify enable register has these event bits, all resetting to 0:
  - bit 2: control falls; bit 3: control rises
  - bit 4: input falls; bit 5: input rises
  - bit 6: output falls; bit 7: output rises

  Bits 1:0 read 0.
- R8: An edge whose enable bit is set sets the pending bit at the same position (address 4) and raises `notify` for one cycle, one cycle after the flag changes. An edge whose enable bit is clear has no effect.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as the clearing write leaves the bit set.
- R10: The live error byte equals `fault_in`, one cycle late.
- R11: A history bit sets whenever its `fault_in` bit is 1, and it is cleared by a read of address 6. An error present in the cycle of that read stays recorded.
- R12: When bit 7 of the byte being read (live or history) is set, that read returns 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 1 | Physical input, asynchronous |
| pin_out | output | 1 | Physical output |
| fault_in | input | 8 | Error inputs, bit 7 is the module fault |
| notify | output | 1 | One-cycle event pulse |

## Verification
Each result has a fixed latency:

| Stimulus | Result | Latency |
|----------|--------|---------|
| Read strobe | `bus_rdata` | 1 edge |
| Write | State and flags | At the sampling edge |
| Write | `notify` / pending bit | 1 further edge |
| `pin_in` change | Flag | 2 edges |
| `pin_in` change | `notify` | 3 edges |
| `fault_in` change | Live byte | 1 edge |

The bench drives on falling edges and samples on the falling edge that follows the edge where the result is due. It waits exactly that many edges before each sample. For the set-versus-clear corner of the pending bits, it places the clearing write so that it lands on the same edge as the pin event.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_IN_PIN = 2'd0,
        ST_IN_SIM = 2'd1,
        ST_OUT    = 2'd2
    } chan_state_e;

    localparam logic [ADDR_W-1:0] A_FLAGS    = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE     = 3'd2;
    localparam logic [ADDR_W-1:0] A_NOTIFY   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PEND     = 3'd4;
    localparam logic [ADDR_W-1:0] A_ERR_LIVE = 3'd5;
    localparam logic [ADDR_W-1:0] A_ERR_HIST = 3'd6;

    localparam int FLAG_CTL  = 3;
    localparam int FLAG_IN   = 6;
    localparam int FLAG_OUT  = 7;
    localparam int SIM_BIT   = 0;
    localparam int FAULT_BIT = 7;

    localparam int NFLAGS = 3;
    localparam int EV_LSB = 2;

    localparam logic [REG_W-1:0] MODE_OUT_CODE = 8'd2;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dio_edge.sv
module dio_edge #(
    parameter  int NFLAGS = 3,
    parameter  int EV_LSB = 2,
    localparam int EV_W   = EV_LSB + 2 * NFLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] flags,
    input  logic [EV_W-1:0]   en,
    input  logic              clr_we,
    input  logic [EV_W-1:0]   clr_mask,
    output logic              notify,
    output logic [EV_W-1:0]   pend
);
    logic [NFLAGS-1:0] prev_q;
    logic [EV_W-1:0]   ev;
    logic [EV_W-1:0]   hit;
    logic [EV_W-1:0]   pend_q;
    logic              notify_q;

    // Per flag: falling event on the even bit, rising event on the odd bit
    generate
        for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
            assign ev[EV_LSB + 2*g]     =  prev_q[g] & ~flags[g];
            assign ev[EV_LSB + 2*g + 1] = ~prev_q[g] &  flags[g];
        end
        if (EV_LSB > 0) begin : g_low
            assign ev[EV_LSB-1:0] = '0;
        end
    endgenerate

    assign hit = ev & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            notify_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            prev_q   <= flags;
            notify_q <= |hit;
            pend_q   <= (pend_q & ~(clr_we ? clr_mask : '0)) | hit;
        end
    end

    assign notify = notify_q;
    assign pend   = pend_q;

    assert_notify_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> $past(|hit));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend & $past(clr_mask & ~hit)) == '0));

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/dio_err.sv
module dio_err #(
    parameter int W         = 8,
    parameter int FAULT_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] err_in,
    input  logic         hist_clr,
    output logic [W-1:0] live,
    output logic [W-1:0] hist,
    output logic [W-1:0] live_view,
    output logic [W-1:0] hist_view
);
    localparam logic [W-1:0] FAULT_ONLY = W'(1) << FAULT_BIT;

    logic [W-1:0] live_q;
    logic [W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            hist_q <= '0;
        end else begin
            live_q <= err_in;
            // a present error wins over the clear, so nothing is lost
            hist_q <= (hist_clr ? '0 : hist_q) | err_in;
        end
    end

    assign live      = live_q;
    assign hist      = hist_q;
    assign live_view = live_q[FAULT_BIT] ? FAULT_ONLY : live_q;
    assign hist_view = hist_q[FAULT_BIT] ? FAULT_ONLY : hist_q;

    assert_live_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live == $past(err_in)));

    assert_hist_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_in != '0) |=> ((hist & $past(err_in)) == $past(err_in)));

    assert_hist_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_clr |=> ((hist & $past(hist)) == $past(hist)));
endmodule

// File: rtl/dio_channel.sv
module dio_channel
    import dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    input  logic [REG_W-1:0]  fault_in,
    output logic              notify
);
    localparam int EV_W = EV_LSB + 2 * NFLAGS;
    localparam logic [REG_W-1:0] EV_MASK = ~((REG_W'(1) << EV_LSB) - REG_W'(1));

    chan_state_e state_q, state_d;

    logic             sim_en_q;
    logic             sim_val_q;
    logic             out_q;
    logic [EV_W-1:0]  nen_q;
    logic             pin_s;
    logic             in_flag, ctl_flag;
    logic [NFLAGS-1:0] flag_vec;
    logic [EV_W-1:0]  pend;
    logic [REG_W-1:0] err_live, err_hist, err_live_view, err_hist_view;
    logic [REG_W-1:0] flags_rd, rd_mux, rdata_q;

    logic wr_flags, wr_enable, wr_mode, wr_notify, wr_pend, rd_hist, mode_is_out;

    assign wr_flags    = bus_wr && (bus_addr == A_FLAGS);
    assign wr_enable   = bus_wr && (bus_addr == A_ENABLE);
    assign wr_mode     = bus_wr && (bus_addr == A_MODE);
    assign wr_notify   = bus_wr && (bus_addr == A_NOTIFY);
    assign wr_pend     = bus_wr && (bus_addr == A_PEND);
    assign rd_hist     = bus_rd && (bus_addr == A_ERR_HIST);
    assign mode_is_out = (bus_wdata == MODE_OUT_CODE);

    dio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (pin_in),
        .q (pin_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IN_PIN;
        else        state_q <= state_d;
    end

    // Next state: T_TO_OUT, T_TO_IN, T_SIM_ON, T_SIM_OFF
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IN_PIN: begin
                if (wr_mode && mode_is_out)             state_d = ST_OUT;
                else if (wr_enable && bus_wdata[SIM_BIT]) state_d = ST_IN_SIM;
            end
            ST_IN_SIM: begin
                if (wr_mode && mode_is_out)              state_d = ST_OUT;
                else if (wr_enable && !bus_wdata[SIM_BIT]) state_d = ST_IN_PIN;
            end
            ST_OUT: begin
                if (wr_mode && !mode_is_out)
                    state_d = sim_en_q ? ST_IN_SIM : ST_IN_PIN;
            end
            default: state_d = ST_IN_PIN;
        endcase
    end

    // Host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sim_en_q  <= 1'b0;
            sim_val_q <= 1'b0;
            out_q     <= 1'b0;
            nen_q     <= '0;
        end else begin
            if (wr_enable) sim_en_q <= bus_wdata[SIM_BIT];
            if (wr_notify) nen_q    <= bus_wdata[EV_W-1:0] & EV_MASK[EV_W-1:0];
            if (state_q == ST_IN_SIM && wr_flags) sim_val_q <= bus_wdata[FLAG_IN];
            if (state_d != ST_OUT)
                out_q <= 1'b0;
            else if (state_q == ST_OUT && wr_flags)
                out_q <= bus_wdata[FLAG_OUT];
        end
    end

    // Flag outputs per state
    always_comb begin
        unique case (state_q)
            ST_IN_PIN: in_flag = pin_s;
            ST_IN_SIM: in_flag = sim_val_q;
            ST_OUT:    in_flag = out_q;
            default:   in_flag = 1'b0;
        endcase
        ctl_flag = in_flag;
    end

    assign flag_vec = {out_q, in_flag, ctl_flag};
    assign pin_out  = out_q;

    dio_edge #(.NFLAGS(NFLAGS), .EV_LSB(EV_LSB)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .flags (flag_vec),
        .en (nen_q),
        .clr_we (wr_pend),
        .clr_mask (bus_wdata[EV_W-1:0]),
        .notify (notify),
        .pend (pend)
    );

    dio_err #(.W(REG_W), .FAULT_BIT(FAULT_BIT)) u_err (
        .clk (clk),
        .rst_n (rst_n),
        .err_in (fault_in),
        .hist_clr (rd_hist),
        .live (err_live),
        .hist (err_hist),
        .live_view (err_live_view),
        .hist_view (err_hist_view)
    );

    // Read path
    always_comb begin
        flags_rd           = '0;
        flags_rd[FLAG_OUT] = out_q;
        flags_rd[FLAG_IN]  = in_flag;
        flags_rd[FLAG_CTL] = ctl_flag;
        unique case (bus_addr)
            A_FLAGS:    rd_mux = flags_rd;
            A_ENABLE:   rd_mux = REG_W'(sim_en_q);
            A_MODE:     rd_mux = (state_q == ST_OUT) ? MODE_OUT_CODE : '0;
            A_NOTIFY:   rd_mux = REG_W'(nen_q);
            A_PEND:     rd_mux = REG_W'(pend);
            A_ERR_LIVE: rd_mux = err_live_view;
            A_ERR_HIST: rd_mux = err_hist_view;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= bus_rd ? rd_mux : '0;
    end

    assign bus_rdata = rdata_q;

    assert_out_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OUT) |-> !pin_out);

    assert_out_by_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_out) |-> $past(wr_flags && bus_wdata[FLAG_OUT]));

    assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_MODE) |=> (bus_rdata == '0 || bus_rdata == MODE_OUT_CODE));

    assert_fault_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ERR_LIVE && err_live[FAULT_BIT]) |=> (bus_rdata == 8'h80));

    assert_hist_fault_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hist && err_hist[FAULT_BIT]) |=> (bus_rdata == 8'h80));

    assert_sim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IN_SIM && state_d == ST_IN_SIM && !wr_flags) |=> $stable(in_flag));
endmodule

// File: tb/sim_dio_channel.sv
`timescale 1ns/1ps
module sim_dio_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_s = 1'b0;
    logic       rd_s = 1'b0;
    logic [7:0] wdata = '0;
    logic       pin = 1'b0;
    logic [7:0] err = '0;
    logic [7:0] rdata;
    logic       pout;
    logic       ntf;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dio_channel u0 (
        .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wr (wr_s), .bus_rd (rd_s),
        .bus_wdata (wdata), .bus_rdata (rdata), .pin_in (pin), .pin_out (pout),
        .fault_in (err), .notify (ntf)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_s = 1'b1;
        @(negedge clk); wr_s = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_s = 1'b1;
        @(negedge clk); rd_s = 1'b0; d = rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] prev;
        logic [7:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R1 R2 R7
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 reset read addr %0d", a), d, 8'h00);
        end
        chk("R5 reset pin_out", {7'd0, pout}, 8'h00);
        chk("R8 reset notify", {7'd0, ntf}, 8'h00);

        // Input mode, pin sampled: R3, with ignored host writes R5 R6
        for (int p = 0; p < 2; p++) begin
            @(negedge clk); pin = p[0];
            wr(3'd0, 8'hC0);
            repeat (3) @(negedge clk);
            rd(3'd0, d);
            chk("R3 input flag follows pin", d, p ? 8'h48 : 8'h00);
            chk("R5 pin_out low in input mode", {7'd0, pout}, 8'h00);
        end
        rd(3'd7, d);
        chk("R1 unused address", d, 8'h00);

        // Simulation: R6 (earlier bit6 writes were ignored, value still 0)
        wr(3'd1, 8'hFF);
        rd(3'd1, d);
        chk("R6 enable readback", d, 8'h01);
        rd(3'd0, d);
        chk("R6 sim value zero from reset", d, 8'h00);
        for (int v = 0; v < 2; v++) begin
            for (int p = 0; p < 2; p++) begin
                @(negedge clk); pin = p[0];
                wr(3'd0, {v[0], v[0], 6'd0});
                repeat (3) @(negedge clk);
                rd(3'd0, d);
                chk("R6 sim flag from host", d, v ? 8'h48 : 8'h00);
                chk("R5 pin_out low in sim mode", {7'd0, pout}, 8'h00);
            end
        end
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        repeat (3) @(negedge clk);
        rd(3'd0, d);
        chk("R3 pin again after sim off", d, {1'b0, pin, 2'b00, pin, 3'b000});

        // Output mode: R2 R4 R5
        @(negedge clk); pin = 1'b0;
        repeat (3) @(negedge clk);
        wr(3'd2, 8'd2);
        rd(3'd2, d);
        chk("R2 mode output readback", d, 8'h02);
        for (int v = 0; v < 2; v++) begin
            for (int p = 0; p < 2; p++) begin
                @(negedge clk); pin = p[0];
                wr(3'd0, {v[0], 7'h40});
                repeat (3) @(negedge clk);
                rd(3'd0, d);
                chk("R4 flags follow out flag", d, v ? 8'hC8 : 8'h00);
                chk("R5 pin_out equals out flag", {7'd0, pout}, {7'd0, v[0]});
            end
        end
        wr(3'd0, 8'h80);
        chk("R5 pin_out set", {7'd0, pout}, 8'h01);
        wr(3'd2, 8'd5);
        chk("R5 pin_out cleared leaving output", {7'd0, pout}, 8'h00);
        rd(3'd2, d);
        chk("R2 mode 5 is input", d, 8'h00);
        wr(3'd0, 8'h80);
        chk("R5 out write ignored in input", {7'd0, pout}, 8'h00);
        wr(3'd2, 8'd2);
        rd(3'd0, d);
        chk("R5 out flag restarts at 0", d, 8'h00);
        for (int mv = 0; mv < 8; mv++) begin
            wr(3'd2, 8'(mv));
            rd(3'd2, d);
            chk("R2 mode sweep", d, (mv == 2) ? 8'h02 : 8'h00);
        end

        // Notify enable register: R7
        @(negedge clk); pin = 1'b0;
        repeat (3) @(negedge clk);
        wr(3'd3, 8'hFF);
        rd(3'd3, d);
        chk("R7 notify enable readback", d, 8'hFC);

        // Output-mode edges, all 64 enable masks: R8 R9
        wr(3'd2, 8'd2);
        for (int i = 0; i < 64; i++) begin
            m = 8'(i << 2);
            wr(3'd3, m);
            wr(3'd4, 8'hFF);
            wr(3'd0, 8'h80);
            @(negedge clk);
            chk("R8 notify on rise", {7'd0, ntf}, {7'd0, (m & 8'hA8) != 0});
            @(negedge clk);
            chk("R8 notify one cycle", {7'd0, ntf}, 8'h00);
            rd(3'd4, d);
            chk("R8 pending after rise", d, m & 8'hA8);
            wr(3'd4, 8'hFF);
            wr(3'd0, 8'h00);
            @(negedge clk);
            chk("R8 notify on fall", {7'd0, ntf}, {7'd0, (m & 8'h54) != 0});
            rd(3'd4, d);
            chk("R8 pending after fall", d, m & 8'h54);
        end

        // Input-pin edges: R8, then set beats clear: R9
        wr(3'd2, 8'd0);
        wr(3'd3, 8'hFC);
        wr(3'd4, 8'hFF);
        @(negedge clk); pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 notify from pin rise", {7'd0, ntf}, 8'h01);
        @(negedge clk);
        chk("R8 notify pulse ends", {7'd0, ntf}, 8'h00);
        rd(3'd4, d);
        chk("R8 pin rise pending", d, 8'h28);
        @(negedge clk); pin = 1'b0;
        @(negedge clk);
        wr(3'd4, 8'hFF);
        rd(3'd4, d);
        chk("R9 new event beats clear", d, 8'h14);
        wr(3'd4, 8'h04);
        rd(3'd4, d);
        chk("R9 partial write-1-clear", d, 8'h10);
        wr(3'd4, 8'h00);
        rd(3'd4, d);
        chk("R9 writing zero keeps bits", d, 8'h10);

        // Errors: R10 R11
        @(negedge clk); err = 8'h00;
        rd(3'd6, d);
        prev = 8'h00;
        for (int e = 0; e < 128; e++) begin
            @(negedge clk); err = 8'(e);
            rd(3'd5, d);
            chk("R10 live error copy", d, 8'(e));
            rd(3'd6, d);
            chk("R11 history accumulates", d, prev | 8'(e));
            prev = 8'(e);
        end
        @(negedge clk); err = 8'h00;
        rd(3'd6, d);
        rd(3'd6, d);
        chk("R11 history cleared by read", d, 8'h00);
        @(negedge clk); err = 8'h02; addr = 3'd6; rd_s = 1'b1;
        @(negedge clk); rd_s = 1'b0; err = 8'h00; d = rdata;
        chk("R11 read before new error", d, 8'h00);
        rd(3'd6, d);
        chk("R11 error in read cycle kept", d, 8'h02);
        rd(3'd6, d);
        chk("R11 history empty", d, 8'h00);

        // Module fault: R12
        @(negedge clk); err = 8'h83;
        rd(3'd5, d);
        chk("R12 live masked by fault", d, 8'h80);
        rd(3'd6, d);
        chk("R12 history masked by fault", d, 8'h80);
        @(negedge clk); err = 8'h00;
        rd(3'd5, d);
        chk("R10 live clears", d, 8'h00);
        rd(3'd6, d);
        chk("R12 history still faulted", d, 8'h80);
        rd(3'd6, d);
        chk("R11 history cleared after fault", d, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule